// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where a 32-bit core with fixed 4-byte instructions fetches next. It takes the current program counter, a decoded control-flow kind, two register operand values, a 16-bit signed immediate and a 26-bit jump index. It returns the next PC, a flag that says whether control flow left the sequential path, and a link address with a write strobe and destination register number for the linking jump.

Three target forms are built in parallel. The first is a PC-relative branch target, counted in instructions from the following instruction. The second is a region-relative jump target that keeps the upper bits of the PC. The third is a full register value. A compare stage evaluates the register-equality conditions, and a selector picks the result. The unit is purely combinational and sits between decode and fetch. The caller registers its outputs.

Top module: `npc_unit`

## Requirements
- R1: For kind code 0 (no control flow) and the reserved code 7, `npc_o` equals `pc_i + 4` and `taken_o` is 0.
- R2: Kind code 1 (branch on equal) is taken exactly when `opa_i == opb_i`. When taken, `npc_o = pc_i + 4 + (sign_extend(imm_i) << 2)`. Otherwise `npc_o = pc_i + 4`.
- R3: Kind code 2 (branch on not-equal) is taken exactly when `opa_i != opb_i`. It uses the same target and fall-through rules as R2.
- R4: Kind code 3 (branch on zero) is taken exactly when `opa_i == 0`, whatever the value of `opb_i`. It uses the same target and fall-through rules as R2.
- R5: Kind code 4 (direct jump) is always taken. `npc_o = {pc_i[31:28], jidx_i, 2'b00}`, so the top four bits come from the current PC and not from PC+4.
- R6: Kind code 5 (jump and link) forms the same target as R5 and is taken. It drives `link_we_o = 1`, `link_addr_o = pc_i + 4` and `link_reg_o = 31`.
- R7: Kind code 6 (jump via register) is taken and drives `npc_o = opa_i` unchanged, with no alignment forced.
- R8: `link_we_o` is 0 for every kind code other than 5.
- R9: All PC arithmetic wraps modulo 2^32. For example, `pc_i = 32'hFFFF_FFFC` falls through to 0, and a negative offset from a low PC wraps to the top of the address space.
- R10: The immediate covers +32767 to -32768 instructions. `imm_i = 16'h7FFF` adds 131068 bytes to PC+4, and `imm_i = 16'h8000` subtracts 131072 bytes from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the current instruction |
| cf_kind_i | input | 3 | Control-flow kind code (0 none, 1 beq, 2 bne, 3 bez, 4 jump, 5 jump-and-link, 6 jump-register, 7 reserved) |
| opa_i | input | 32 | First register operand; also the jump-register target and the zero-test operand |
| opb_i | input | 32 | Second register operand for the equality compares |
| imm_i | input | 16 | Signed branch offset in instructions |
| jidx_i | input | 26 | Word index for direct jumps |
| npc_o | output | 32 | Next program counter |
| taken_o | output | 1 | High when the next PC leaves the sequential path |
| link_addr_o | output | 32 | Return address (PC+4) |
| link_we_o | output | 1 | Write strobe for the link register |
| link_reg_o | output | 5 | Destination register number for the link write |

## Verification
The hardest conditions to reach from the ports are operand equality and a zero operand. With independent random 32-bit operands, these almost never occur, so the equal-branch and zero-branch taken paths would go untested. The stimulus therefore copies `opa_i` into `opb_i`, or forces `opa_i` to zero, on about half of the random steps. Directed steps then place the PC at the top and bottom of the address space and drive both immediate extremes, so that wraparound and full reach are seen alongside region boundaries for the jumps.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [2:0] {
        CF_NONE = 3'd0,
        CF_BEQ  = 3'd1,
        CF_BNE  = 3'd2,
        CF_BEZ  = 3'd3,
        CF_JMP  = 3'd4,
        CF_JAL  = 3'd5,
        CF_JREG = 3'd6,
        CF_RSVD = 3'd7
    } cf_kind_e;

    typedef enum logic [1:0] {
        SRC_SEQ = 2'd0,
        SRC_BR  = 2'd1,
        SRC_JMP = 2'd2,
        SRC_REG = 2'd3
    } tgt_src_e;

    typedef struct packed {
        logic     is_branch;
        logic     is_uncond;
        logic     links;
        tgt_src_e uncond_src;
    } cf_class_t;

    function automatic cf_class_t classify(input cf_kind_e kind);
        cf_class_t c;
        c = '{is_branch: 1'b0, is_uncond: 1'b0, links: 1'b0, uncond_src: SRC_SEQ};
        unique case (kind)
            CF_BEQ, CF_BNE, CF_BEZ: c.is_branch = 1'b1;
            CF_JMP: begin
                c.is_uncond  = 1'b1;
                c.uncond_src = SRC_JMP;
            end
            CF_JAL: begin
                c.is_uncond  = 1'b1;
                c.links      = 1'b1;
                c.uncond_src = SRC_JMP;
            end
            CF_JREG: begin
                c.is_uncond  = 1'b1;
                c.uncond_src = SRC_REG;
            end
            default: c = c;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cf_kind_e          kind_i,
    input  logic [XLEN-1:0]   opa_i,
    input  logic [XLEN-1:0]   opb_i,
    output logic              cond_hit_o
);

    logic ops_equal;
    logic opa_zero;

    assign ops_equal = (opa_i == opb_i);
    assign opa_zero  = ~|opa_i;

    always_comb begin
        unique case (kind_i)
            CF_BEQ:  cond_hit_o = ops_equal;
            CF_BNE:  cond_hit_o = ~ops_equal;
            CF_BEZ:  cond_hit_o = opa_zero;
            default: cond_hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
    parameter int XLEN        = 32,
    parameter int IMM_W       = 16,
    parameter int IDX_W       = 26,
    parameter int INSTR_BYTES = 4
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [IDX_W-1:0] jidx_i,
    output logic [XLEN-1:0]  seq_pc_o,
    output logic [XLEN-1:0]  br_tgt_o,
    output logic [XLEN-1:0]  jmp_tgt_o
);

    localparam int ALIGN_W  = $clog2(INSTR_BYTES);
    localparam int EXT_W    = XLEN - IMM_W - ALIGN_W;
    localparam int REGION_W = XLEN - IDX_W - ALIGN_W;

    logic [XLEN-1:0] byte_off;

    assign seq_pc_o = pc_i + XLEN'(INSTR_BYTES);

    generate
        if (EXT_W > 0) begin : g_sext
            assign byte_off = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, {ALIGN_W{1'b0}}};
        end else begin : g_trunc
            assign byte_off = XLEN'({imm_i, {ALIGN_W{1'b0}}});
        end
    endgenerate

    assign br_tgt_o = seq_pc_o + byte_off;

    generate
        if (REGION_W > 0) begin : g_region
            assign jmp_tgt_o = {pc_i[XLEN-1 -: REGION_W], jidx_i, {ALIGN_W{1'b0}}};
        end else begin : g_flat
            assign jmp_tgt_o = XLEN'({jidx_i, {ALIGN_W{1'b0}}});
        end
    endgenerate

endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cf_class_t        cls_i,
    input  logic             cond_hit_i,
    input  logic [XLEN-1:0]  seq_pc_i,
    input  logic [XLEN-1:0]  br_tgt_i,
    input  logic [XLEN-1:0]  jmp_tgt_i,
    input  logic [XLEN-1:0]  reg_tgt_i,
    output logic [XLEN-1:0]  npc_o,
    output logic             taken_o,
    output logic             link_we_o
);

    tgt_src_e src;

    always_comb begin
        src = SRC_SEQ;
        if (cls_i.is_uncond)
            src = cls_i.uncond_src;
        else if (cls_i.is_branch && cond_hit_i)
            src = SRC_BR;
    end

    always_comb begin
        unique case (src)
            SRC_BR:  npc_o = br_tgt_i;
            SRC_JMP: npc_o = jmp_tgt_i;
            SRC_REG: npc_o = reg_tgt_i;
            default: npc_o = seq_pc_i;
        endcase
    end

    assign taken_o   = (src != SRC_SEQ);
    assign link_we_o = cls_i.links;

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int IMM_W       = 16,
    parameter int IDX_W       = 26,
    parameter int INSTR_BYTES = 4,
    parameter int RIDX_W      = 5,
    parameter int LINK_REG    = 31
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [2:0]        cf_kind_i,
    input  logic [XLEN-1:0]   opa_i,
    input  logic [XLEN-1:0]   opb_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [IDX_W-1:0]  jidx_i,
    output logic [XLEN-1:0]   npc_o,
    output logic              taken_o,
    output logic [XLEN-1:0]   link_addr_o,
    output logic              link_we_o,
    output logic [RIDX_W-1:0] link_reg_o
);

    cf_kind_e        kind;
    cf_class_t       cls;
    logic            cond_hit;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] jmp_tgt;

    assign kind = cf_kind_e'(cf_kind_i);
    assign cls  = classify(kind);

    npc_cond_eval #(.XLEN(XLEN)) i_cond (
        .kind_i     (kind),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .cond_hit_o (cond_hit)
    );

    npc_target_gen #(
        .XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W), .INSTR_BYTES(INSTR_BYTES)
    ) i_tgt (
        .pc_i      (pc_i),
        .imm_i     (imm_i),
        .jidx_i    (jidx_i),
        .seq_pc_o  (seq_pc),
        .br_tgt_o  (br_tgt),
        .jmp_tgt_o (jmp_tgt)
    );

    npc_select #(.XLEN(XLEN)) i_sel (
        .cls_i      (cls),
        .cond_hit_i (cond_hit),
        .seq_pc_i   (seq_pc),
        .br_tgt_i   (br_tgt),
        .jmp_tgt_i  (jmp_tgt),
        .reg_tgt_i  (opa_i),
        .npc_o      (npc_o),
        .taken_o    (taken_o),
        .link_we_o  (link_we_o)
    );

    assign link_addr_o = seq_pc;
    assign link_reg_o  = RIDX_W'(LINK_REG);

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5
) (
    input logic [XLEN-1:0]   pc_i,
    input logic [2:0]        cf_kind_i,
    input logic [XLEN-1:0]   opa_i,
    input logic [XLEN-1:0]   opb_i,
    input logic [XLEN-1:0]   npc_o,
    input logic              taken_o,
    input logic [XLEN-1:0]   link_addr_o,
    input logic              link_we_o,
    input logic [RIDX_W-1:0] link_reg_o
);

    logic [XLEN-1:0] nxt;
    logic            known;

    assign nxt   = pc_i + XLEN'(4);
    assign known = !$isunknown({pc_i, cf_kind_i, opa_i, opb_i});

    always_comb begin
        if (known) begin
            // R1
            a_r1_sequential: assert (!(cf_kind_i == 3'd0 || cf_kind_i == 3'd7)
                                     || (npc_o == nxt && !taken_o));
            // R2
            a_r2_beq_cond: assert (cf_kind_i != 3'd1 || taken_o == (opa_i == opb_i));
            a_r2_fallthrough: assert (!(cf_kind_i inside {3'd1, 3'd2, 3'd3}) || taken_o
                                      || npc_o == nxt);
            // R3
            a_r3_bne_cond: assert (cf_kind_i != 3'd2 || taken_o == (opa_i != opb_i));
            // R4
            a_r4_bez_cond: assert (cf_kind_i != 3'd3 || taken_o == (opa_i == '0));
            // R5
            a_r5_region_kept: assert (!(cf_kind_i == 3'd4 || cf_kind_i == 3'd5)
                                      || (taken_o && npc_o[XLEN-1 -: 4] == pc_i[XLEN-1 -: 4]
                                          && npc_o[1:0] == 2'b00));
            // R6
            a_r6_link_fields: assert (!link_we_o
                                      || (cf_kind_i == 3'd5 && link_addr_o == nxt
                                          && link_reg_o == RIDX_W'(31)));
            // R7
            a_r7_reg_target: assert (cf_kind_i != 3'd6 || (npc_o == opa_i && taken_o));
            // R8
            a_r8_no_link: assert (cf_kind_i == 3'd5 || !link_we_o);
        end
    end

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) i_npc_unit_chk (
    .pc_i        (pc_i),
    .cf_kind_i   (cf_kind_i),
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .npc_o       (npc_o),
    .taken_o     (taken_o),
    .link_addr_o (link_addr_o),
    .link_we_o   (link_we_o),
    .link_reg_o  (link_reg_o)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;

    logic        clk = 1'b0;
    always #10 clk = ~clk;

    logic [31:0] pc, opa, opb, npc, link_addr;
    logic [2:0]  kind;
    logic [15:0] imm;
    logic [25:0] jidx;
    logic        taken, link_we;
    logic [4:0]  link_reg;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    npc_unit i_npc_unit (
        .pc_i        (pc),
        .cf_kind_i   (kind),
        .opa_i       (opa),
        .opb_i       (opb),
        .imm_i       (imm),
        .jidx_i      (jidx),
        .npc_o       (npc),
        .taken_o     (taken),
        .link_addr_o (link_addr),
        .link_we_o   (link_we),
        .link_reg_o  (link_reg)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(int k);
        case (k)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R1";
        endcase
    endfunction

    task automatic step(int k, logic [31:0] p, logic [31:0] a, logic [31:0] b,
                        logic [15:0] im, logic [25:0] ix, string tag_in);
        longint unsigned mask = 64'hFFFF_FFFF;
        longint unsigned fall;
        longint unsigned bt;
        longint signed   off;
        logic [31:0]     e_npc;
        bit              e_tk;
        string           tag;
        @(posedge clk);
        kind = 3'(k); pc = p; opa = a; opb = b; imm = im; jidx = ix;
        @(negedge clk);
        tag  = (tag_in == "") ? tag_of(k) : tag_in;
        fall = (longint'(p) + 4) & mask;
        off  = longint'($signed(im)) * 4;
        bt   = longint'(fall + off) & mask;
        e_tk = 1'b0;
        case (k)
            1: e_tk = (a == b);
            2: e_tk = (a != b);
            3: e_tk = (a == 0);
            4, 5, 6: e_tk = 1'b1;
            default: e_tk = 1'b0;
        endcase
        if (k == 4 || k == 5)
            e_npc = (p & 32'hF000_0000) | (32'(ix) * 4);
        else if (k == 6)
            e_npc = a;
        else if (e_tk)
            e_npc = 32'(bt);
        else
            e_npc = 32'(fall);
        check(tag, "npc", npc, e_npc);
        check(tag, "taken", 32'(taken), 32'(e_tk));
        if (k == 5) begin
            check("R6", "link_we", 32'(link_we), 32'd1);
            check("R6", "link_addr", link_addr, 32'(fall));
            check("R6", "link_reg", 32'(link_reg), 32'd31);
        end else begin
            check("R8", "link_we", 32'(link_we), 32'd0);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        kind = 3'd0; pc = '0; opa = '0; opb = '0; imm = '0; jidx = '0;
        // reset-like idle state: no control flow from address zero
        step(0, 32'h0, 32'h0, 32'h0, 16'h0, 26'h0, "R1");
        step(7, 32'h0000_1000, 32'h5, 32'h5, 16'h0010, 26'h1, "R1");
        // equality branches
        step(1, 32'h0040_0000, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'h0002, 26'h0, "R2");
        step(1, 32'h0040_0000, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 16'h0002, 26'h0, "R2");
        step(2, 32'h0040_0010, 32'h1, 32'h2, 16'hFFFC, 26'h0, "R3");
        step(2, 32'h0040_0010, 32'h7, 32'h7, 16'hFFFC, 26'h0, "R3");
        // zero branch ignores second operand
        step(3, 32'h0000_2000, 32'h0, 32'hFFFF_FFFF, 16'h0008, 26'h0, "R4");
        step(3, 32'h0000_2000, 32'h1, 32'h0, 16'h0008, 26'h0, "R4");
        // region jumps use current PC top bits
        step(4, 32'hA123_4560, 32'h0, 32'h0, 16'h0, 26'h3FF_FFFF, "R5");
        step(4, 32'hEFFF_FFFC, 32'h0, 32'h0, 16'h0, 26'h000_0001, "R5");
        step(5, 32'h1000_0100, 32'h0, 32'h0, 16'h0, 26'h012_3456, "R6");
        // register jump, unaligned value kept
        step(6, 32'h0000_0040, 32'h8000_0003, 32'h0, 16'h0, 26'h0, "R7");
        // wraparound
        step(0, 32'hFFFF_FFFC, 32'h0, 32'h0, 16'h0, 26'h0, "R9");
        step(1, 32'h0000_0004, 32'h3, 32'h3, 16'hFFF0, 26'h0, "R9");
        step(2, 32'hFFFF_FFF0, 32'h1, 32'h0, 16'h0010, 26'h0, "R9");
        step(4, 32'hFFFF_FFFC, 32'h0, 32'h0, 16'h0, 26'h0, "R9");
        // offset extremes
        step(1, 32'h1000_0000, 32'h9, 32'h9, 16'h7FFF, 26'h0, "R10");
        step(3, 32'h1000_0000, 32'h0, 32'h9, 16'h8000, 26'h0, "R10");
        // mixed stimulus with forced equality and zero operands
        for (int i = 0; i < 600; i++) begin
            int          k;
            logic [31:0] a, b;
            k = int'($urandom_range(0, 7));
            a = $urandom;
            b = $urandom;
            if ($urandom_range(0, 1) == 1) b = a;
            if (k == 3 && $urandom_range(0, 1) == 1) a = 32'h0;
            step(k, $urandom, a, b, 16'($urandom), 26'($urandom), "");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule